// File: doc/BRIEF.md
# Fixed-Point Taylor Sine Evaluator

This block turns a 32-bit phase word into a signed 32-bit sine sample and scales that sample by a signed 32-bit amplitude. The phase word covers one full turn over its 2^32 codes. The block first folds the phase onto the half circle between -90 and +90 degrees. It then works out an odd power series in the folded angle using only rounding multiply-high products, left shifts, additions and subtractions.

A single multiplier is shared over a fixed sequence of steps, one step per clock. The caller pulses `start_i` with the phase, amplitude and order selection presented on that cycle. When the result is ready the block raises `done_o` for exactly one cycle. The order input selects one of two series. The full series runs to the eleventh power and costs thirteen cycles. The short series stops at the seventh power and costs nine cycles.

Top module: `sine_taylor_eval`

## Requirements
- R1: The folded angle equals the phase read as signed when phase[31:30] is 2'b00 or 2'b11. Otherwise it equals 0x7FFFFFFF minus the phase. As a consequence, phases P and 0x7FFFFFFF−P give identical outputs when P lies in the second quadrant.
- R2: With `full_order_i`=1, `sample_o` matches, bit for bit, the chain built from mulhr(a,b) = (a·b + 2^31) >>> 32. The chain is: p1 = mulhr(angle<<1, 1686629713), p2 = mulhr(p1,p1)<<3, p3 = mulhr(p2,p1)<<3, sum = (p1<<1) − mulhr(p3,1431655765), p5 = mulhr(p3,p2)<<1, sum += mulhr(p5,286331153), p7 = mulhr(p5,p2), sum −= mulhr(p7,54539267), p9 = mulhr(p7,p2), sum += mulhr(p9,6059919), p11 = mulhr(p9,p2), sum −= mulhr(p11,440721), sample = mulhr(sum<<1, amplitude). All arithmetic wraps in 32 bits.
- R3: With `full_order_i`=0, the p9 and p11 steps are skipped, and the sample is bit-exact to the chain of R2 ending after the p7 step.
- R4: The output is the series result scaled by the latched amplitude through mulhr, so an amplitude of 0 gives a sample of 0.
- R5: In full order, `done_o` rises 13 clock edges after the edge that accepts `start_i`.
- R6: In short order, `done_o` rises 9 clock edges after the edge that accepts `start_i`.
- R7: `done_o` is high for exactly one cycle per accepted start, and `sample_o` changes only on the cycle on which `done_o` is high.
- R8: While a computation is in progress, `start_i` and any change of phase, amplitude or order are ignored. The running result is unchanged, and no extra `done_o` follows.
- R9: With amplitude 0x7FFFFFFF in full order, phase 0x40000000 gives a sample above 0x3F000000, and phase 0xC0000000 gives a sample below −0x3F000000.
- R10: After reset, `done_o` is 0 and `sample_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| phase_i | input | 32 | Unsigned phase word, 2^32 = one turn |
| amp_i | input | 32 | Signed amplitude scale |
| full_order_i | input | 1 | 1 = eleventh-order series, 0 = seventh-order series |
| sample_o | output | 32 | Signed scaled sine sample |
| done_o | output | 1 | One-cycle pulse marking a new `sample_o` |

## Verification
The bound checker covers the behaviour that follows from timing on every cycle. It checks the one-cycle width of `done_o` and the rule that `sample_o` holds steady between completions. It checks the 13 or 9 cycle latency against a counter started at each accepted request. It also checks that a zero amplitude yields a zero sample. The numerical content cannot be seen by a property and is left to the bench scenarios. These cover bit-exact agreement with an independent model in both orders, the quadrant mirror, the near full-scale peaks at the quarter turns, and the discarding of requests made while the block is busy.

// File: rtl/sine_taylor_pkg.sv
package sine_taylor_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned STEP_W   = 4;
   localparam int unsigned LAST_OP  = 12;   // final amplitude scaling step
   localparam int unsigned SHORT_END = 7;   // last series step of the short chain

   // series coefficients, all as signed Q31 fractions
   localparam logic [WORD_W-1:0] K_PI2  = 32'd1686629713;
   localparam logic [WORD_W-1:0] K_INV3 = 32'd1431655765;
   localparam logic [WORD_W-1:0] K_INV5 = 32'd286331153;
   localparam logic [WORD_W-1:0] K_INV7 = 32'd54539267;
   localparam logic [WORD_W-1:0] K_INV9 = 32'd6059919;
   localparam logic [WORD_W-1:0] K_INV11 = 32'd440721;

   // coefficient used by a given constant step; zero elsewhere
   function automatic logic [WORD_W-1:0] coef_for(input logic [STEP_W-1:0] op);
      case (op)
         4'd0:    coef_for = K_PI2;
         4'd3:    coef_for = K_INV3;
         4'd5:    coef_for = K_INV5;
         4'd7:    coef_for = K_INV7;
         4'd9:    coef_for = K_INV9;
         4'd11:   coef_for = K_INV11;
         default: coef_for = '0;
      endcase
   endfunction
endpackage

// File: rtl/sine_fold.sv
module sine_fold #(
   parameter int unsigned DW = 32
) (
   input  logic [DW-1:0] phase_i,
   output logic [DW-1:0] angle_o
);
   localparam logic [DW-1:0] MIRROR = {1'b0, {(DW-1){1'b1}}};

   // first and fourth quadrant pass straight, second and third are mirrored
   always_comb begin
      if (phase_i[DW-1] == phase_i[DW-2])
         angle_o = phase_i;
      else
         angle_o = MIRROR - phase_i;
   end
endmodule

// File: rtl/sine_mulhr.sv
module sine_mulhr #(
   parameter int unsigned DW = 32
) (
   input  logic signed [DW-1:0] a_i,
   input  logic signed [DW-1:0] b_i,
   output logic signed [DW-1:0] r_o
);
   localparam int unsigned W2 = 2 * DW;
   localparam logic signed [W2-1:0] ROUND = W2'(1) <<< (DW - 1);

   logic signed [W2-1:0] wide_a, wide_b, shifted;

   always_comb begin
      wide_a  = W2'(a_i);
      wide_b  = W2'(b_i);
      shifted = (wide_a * wide_b + ROUND) >>> DW;
      r_o     = DW'(shifted);
   end
endmodule

// File: rtl/sine_seq.sv
module sine_seq
   import sine_taylor_pkg::*;
#(
   parameter int unsigned DW            = 32,
   parameter bit          FULL_ORDER_EN = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [DW-1:0] angle_i,
   input  logic [DW-1:0] amp_i,
   input  logic          full_i,
   output logic [DW-1:0] sample_o,
   output logic          done_o,
   output logic          busy_o
);
   logic [STEP_W-1:0] op_q;
   logic              busy_q, done_q, full_q;
   logic [DW-1:0]     ang_q, amp_q, p1_q, p2_q, pw_q, sum_q, y_q;
   logic [DW-1:0]     op_a, op_b, prod;
   logic              full_eff;

   generate
      if (FULL_ORDER_EN) begin : g_sel_order
         assign full_eff = full_i;
      end else begin : g_short_only
         logic unused_full;
         assign unused_full = full_i;
         assign full_eff    = 1'b0;
      end
   endgenerate

   // operand routing for the shared multiplier
   always_comb begin
      op_b = coef_for(op_q);
      unique case (op_q)
         4'd0:    op_a = ang_q << 1;
         4'd1:    begin op_a = p1_q; op_b = p1_q; end
         4'd2:    begin op_a = p2_q; op_b = p1_q; end
         4'd4, 4'd6, 4'd8, 4'd10:
                  begin op_a = pw_q; op_b = p2_q; end
         4'd12:   begin op_a = sum_q << 1; op_b = amp_q; end
         default: op_a = pw_q;
      endcase
   end

   sine_mulhr #(.DW(DW)) u_mul (
      .a_i (op_a),
      .b_i (op_b),
      .r_o (prod)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         op_q   <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         full_q <= 1'b0;
         ang_q  <= '0;
         amp_q  <= '0;
         p1_q   <= '0;
         p2_q   <= '0;
         pw_q   <= '0;
         sum_q  <= '0;
         y_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               op_q   <= '0;
               ang_q  <= angle_i;
               amp_q  <= amp_i;
               full_q <= full_eff;
            end
         end else begin
            unique case (op_q)
               4'd0:                p1_q  <= prod;
               4'd1:                p2_q  <= prod << 3;
               4'd2:                pw_q  <= prod << 3;
               4'd3:                sum_q <= (p1_q << 1) - prod;
               4'd4:                pw_q  <= prod << 1;
               4'd5, 4'd9:          sum_q <= sum_q + prod;
               4'd6, 4'd8, 4'd10:   pw_q  <= prod;
               4'd7, 4'd11:         sum_q <= sum_q - prod;
               default: begin
                  y_q    <= prod;
                  done_q <= 1'b1;
                  busy_q <= 1'b0;
               end
            endcase
            if (op_q == STEP_W'(SHORT_END) && !full_q)
               op_q <= STEP_W'(LAST_OP);
            else if (op_q != STEP_W'(LAST_OP))
               op_q <= op_q + 1'b1;
         end
      end
   end

   assign sample_o = y_q;
   assign done_o   = done_q;
   assign busy_o   = busy_q;
endmodule

// File: rtl/sine_taylor_eval.sv
module sine_taylor_eval #(
   parameter int unsigned DATA_W        = 32,
   parameter bit          FULL_ORDER_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [DATA_W-1:0] phase_i,
   input  logic [DATA_W-1:0] amp_i,
   input  logic              full_order_i,
   output logic [DATA_W-1:0] sample_o,
   output logic              done_o
);
   generate
      if (DATA_W != sine_taylor_pkg::WORD_W) begin : g_bad_width
         $error("sine_taylor_eval: coefficients are fixed for 32-bit words");
      end
   endgenerate

   logic [DATA_W-1:0] angle;
   logic              busy;

   sine_fold #(.DW(DATA_W)) u_fold (
      .phase_i (phase_i),
      .angle_o (angle)
   );

   sine_seq #(.DW(DATA_W), .FULL_ORDER_EN(FULL_ORDER_EN)) u_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .angle_i  (angle),
      .amp_i    (amp_i),
      .full_i   (full_order_i),
      .sample_o (sample_o),
      .done_o   (done_o),
      .busy_o   (busy)
   );
endmodule

// File: rtl/sine_taylor_chk.sv
module sine_taylor_chk #(
   parameter int unsigned DATA_W        = 32,
   parameter bit          FULL_ORDER_EN = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              full_order_i,
   input logic [DATA_W-1:0] amp_i,
   input logic [DATA_W-1:0] sample_o,
   input logic              done_o,
   input logic              busy
);
   logic [4:0]        cyc_q;
   logic              run_q, long_q;
   logic [DATA_W-1:0] amp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cyc_q  <= '0;
         run_q  <= 1'b0;
         long_q <= 1'b0;
         amp_q  <= '0;
      end else if (start_i && !busy) begin
         cyc_q  <= '0;
         run_q  <= 1'b1;
         long_q <= full_order_i && FULL_ORDER_EN;
         amp_q  <= amp_i;
      end else begin
         if (run_q && cyc_q != 5'd31) cyc_q <= cyc_q + 1'b1;
         if (done_o) run_q <= 1'b0;
      end
   end

   // R7: completion marker lasts a single cycle
   assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R7: the sample only moves when a completion is flagged
   assert_sample_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(sample_o));

   // R5 and R6: latency counted from the accepting edge
   assert_latency_R5_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (run_q && cyc_q == (long_q ? 5'd13 : 5'd9)));

   // R4: zero amplitude gives a zero sample
   assert_zero_amp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && amp_q == '0) |-> (sample_o == '0));
endmodule

bind sine_taylor_eval sine_taylor_chk #(.DATA_W(DATA_W), .FULL_ORDER_EN(FULL_ORDER_EN)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .start_i      (start_i),
   .full_order_i (full_order_i),
   .amp_i        (amp_i),
   .sample_o     (sample_o),
   .done_o       (done_o),
   .busy         (busy)
);

// File: tb/sim_sine_taylor_eval.sv
module sim_sine_taylor_eval;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] val;
      int          lat;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] phase = '0;
   logic [31:0] amp = '0;
   logic        full = 1'b0;
   logic [31:0] sample;
   logic        done;

   int   n_cmp = 0;
   int   n_bad = 0;
   int   cyc = 0;
   int   start_cyc = 0;
   int   done_seen = 0;
   logic prev_done = 1'b0;
   exp_t sb[$];

   sine_taylor_eval u0 (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start), .phase_i (phase),
      .amp_i (amp), .full_order_i (full), .sample_o (sample), .done_o (done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int mh(input int a, input int b);
      longint p;
      p = longint'(a) * longint'(b) + 64'sd2147483648;
      return int'(p >>> 32);
   endfunction

   function automatic logic [31:0] model(input logic [31:0] ph, input logic [31:0] am,
                                         input bit fo);
      int ang, p1, p2, p3, p5, p7, p9, p11, s;
      if (ph >= 32'hC0000000 || ph < 32'h40000000) ang = int'(ph);
      else ang = int'(32'h7FFFFFFF - ph);
      p1 = mh(ang <<< 1, 1686629713);
      p2 = mh(p1, p1) <<< 3;
      p3 = mh(p2, p1) <<< 3;
      s  = (p1 <<< 1) - mh(p3, 1431655765);
      p5 = mh(p3, p2) <<< 1;
      s  = s + mh(p5, 286331153);
      p7 = mh(p5, p2);
      s  = s - mh(p7, 54539267);
      if (fo) begin
         p9  = mh(p7, p2);
         s   = s + mh(p9, 6059919);
         p11 = mh(p9, p2);
         s   = s - mh(p11, 440721);
      end
      return mh(s <<< 1, int'(am));
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: pushes the expected item, pulses start, waits for retirement
   task automatic issue(input logic [31:0] ph, input logic [31:0] am, input bit fo,
                        input string tag);
      exp_t e;
      e.val = model(ph, am, fo);
      e.lat = fo ? 13 : 9;
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      phase = ph; amp = am; full = fo; start = 1'b1;
      start_cyc = cyc + 1;
      @(negedge clk);
      start = 1'b0;
      while (sb.size() > 0) @(negedge clk);
   endtask

   // monitor: compares each completion against the head of the scoreboard
   initial begin
      forever begin
         @(posedge clk); #1;
         if (rst_n) begin
            if (prev_done) check(!done, "R7 done width", 32'(done), 32'd0);
            if (done) begin
               done_seen++;
               if (sb.size() == 0) begin
                  check(1'b0, "R8 unexpected done", sample, 32'd0);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check(sample == e.val, e.tag, sample, e.val);
                  check(cyc - start_cyc == e.lat, (e.lat == 13) ? "R5 latency" : "R6 latency",
                        32'(cyc - start_cyc), 32'(e.lat));
               end
            end
            prev_done = done;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] ya, yb;
      int d0;
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R10 reset done", 32'(done), 32'd0);
      check(sample == 32'd0, "R10 reset sample", sample, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 full order, several phases and amplitudes
      issue(32'h00000000, 32'h7FFFFFFF, 1'b1, "R2 zero phase");
      issue(32'h12345678, 32'h7FFFFFFF, 1'b1, "R2 first quadrant");
      issue(32'hA0000000, 32'h40000000, 1'b1, "R2 third quadrant");
      issue(32'hE1234567, 32'hC0000000, 1'b1, "R2 fourth quadrant negative amp");
      // R3 short order
      issue(32'h12345678, 32'h7FFFFFFF, 1'b0, "R3 short first quadrant");
      issue(32'h9ABCDEF0, 32'h55555555, 1'b0, "R3 short third quadrant");
      // R4 zero amplitude
      issue(32'h2468ACE0, 32'h00000000, 1'b1, "R4 zero amplitude");
      check(sample == 32'd0, "R4 zero sample", sample, 32'd0);

      // R1 mirror of a second-quadrant phase
      issue(32'h30000000, 32'h7FFFFFFF, 1'b1, "R1 mirror base");
      ya = sample;
      issue(32'h4FFFFFFF, 32'h7FFFFFFF, 1'b1, "R1 mirrored phase");
      yb = sample;
      check(ya == yb, "R1 fold symmetry", yb, ya);

      // R9 quarter-turn extremes
      issue(32'h40000000, 32'h7FFFFFFF, 1'b1, "R9 positive peak model");
      check($signed(sample) > 32'sh3F000000, "R9 positive peak", sample, 32'h3F000000);
      issue(32'hC0000000, 32'h7FFFFFFF, 1'b1, "R9 negative peak model");
      check($signed(sample) < -32'sh3F000000, "R9 negative peak", sample, -32'sh3F000000);

      // R8 start and input changes ignored while busy
      begin
         exp_t e;
         e.val = model(32'h21000000, 32'h7FFFFFFF, 1'b1);
         e.lat = 13;
         e.tag = "R8 busy request ignored";
         sb.push_back(e);
         d0 = done_seen;
         @(negedge clk);
         phase = 32'h21000000; amp = 32'h7FFFFFFF; full = 1'b1; start = 1'b1;
         start_cyc = cyc + 1;
         @(negedge clk);
         start = 1'b0;
         repeat (3) @(negedge clk);
         phase = 32'hB0000000; amp = 32'h11111111; full = 1'b0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         while (sb.size() > 0) @(negedge clk);
         repeat (20) @(negedge clk);
         check(done_seen == d0 + 1, "R8 single completion", 32'(done_seen - d0), 32'd1);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule